// File: doc/BRIEF.md
# Slave-Serial FPGA Configuration Sequencer

This block loads a configuration bitstream into a downstream FPGA through its slave-serial pins. A single start pulse from the host begins a full sequence. The block first holds the target's user reset asserted and its I/O enable inactive. It then pulses the active-low program line and waits for the target to release INIT. It shifts the bitstream out one bit per configuration clock, takes bytes from a valid/ready stream, and keeps clocking after the final byte until DONE rises. Once DONE is seen it enables the target's I/Os, holds reset for a fixed interval, releases it, and waits a second equal interval before it reports ready.

The configuration clock runs at half the system clock. A byte is accepted only when the shift register is empty, or is about to become empty, so a stream that keeps valid high gives a gap-free clock. Two faults end the sequence in an error state with a sticky flag. The first is INIT falling again while data is being shifted. The second is DONE not rising within a set number of extra configuration clocks after the last byte. Another start pulse clears the flag and begins a new sequence.

Top module: `fpga_ss_loader`

## Requirements
- R1: After reset the outputs are prog_n_o=1, user_rst_n_o=1, io_en_n_o=1, cclk_o=0, s_ready_o=0, busy_o=0, ready_o=0, err_init_o=0 and err_timeout_o=0.
- R2: A start pulse drives prog_n_o low for exactly PROG_CYC system cycles. From that point through data loading, user_rst_n_o is 0 and io_en_n_o is 1.
- R3: s_ready_o stays 0 while init_n_i is low. It rises only after the program pulse has ended and init_n_i has returned high.
- R4: Each accepted byte is sent MSB first. Each bit is on din_o in the cycle before its rising edge of cclk_o and is unchanged at that edge. There is one rising edge per bit, so a byte takes 8 edges, and cclk_o is never high for two cycles in a row.
- R5: When s_valid_i stays high, consecutive rising edges of cclk_o are exactly 2 system cycles apart from the first bit until DONE is seen. This holds across byte boundaries and into the post-load clocking.
- R6: If init_n_i goes low while data is being shifted, the block stops clocking and sets err_init_o=1. It drops busy_o and s_ready_o, and the remaining bytes are not sent.
- R7: After the byte marked with s_last_i, cclk_o keeps toggling until done_i is high. Then io_en_n_o goes 0 with user_rst_n_o still 0 for DELAY_CYC cycles, where DELAY_CYC = CLK_HZ/1e6 x DELAY_US. After that user_rst_n_o is 1 for DELAY_CYC cycles before ready_o goes 1.
- R8: If done_i does not rise within DONE_WAIT rising edges of cclk_o after the last data bit, the block sets err_timeout_o=1, leaves io_en_n_o at 1 and does not raise ready_o.
- R9: A start pulse is ignored while busy_o is 1. The program line is not pulsed again and the load completes normally.
- R10: A start pulse from the ready or error state begins a new sequence and clears both error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that begins a configuration sequence |
| s_data_i | input | DATA_W | Bitstream byte |
| s_valid_i | input | 1 | Byte on s_data_i is valid |
| s_last_i | input | 1 | Byte on s_data_i is the final one |
| s_ready_o | output | 1 | Block accepts the byte this cycle |
| prog_n_o | output | 1 | Active-low program line to the target |
| init_n_i | input | 1 | Active-low INIT line from the target |
| done_i | input | 1 | Active-high DONE line from the target |
| cclk_o | output | 1 | Configuration clock |
| din_o | output | 1 | Serial configuration data |
| user_rst_n_o | output | 1 | Active-low user reset of the target |
| io_en_n_o | output | 1 | Active-low I/O enable of the target |
| busy_o | output | 1 | Sequence in progress |
| ready_o | output | 1 | Target configured and released |
| err_init_o | output | 1 | Sticky: INIT fell during loading |
| err_timeout_o | output | 1 | Sticky: DONE did not rise in time |

## Verification
The bench models the target. It pulls INIT low during the program pulse and releases it a few cycles later. It rebuilds each byte from din_o at the cclk_o rising edges and raises DONE after a few extra clocks. A design that sent bits LSB first, or moved din_o at the clock edge, would rebuild wrong bytes. One that left an idle cycle between bytes would show a 3-cycle clock gap. One that opened the stream before INIT released would raise s_ready_o while INIT is low. The bench counts the program pulse width and both post-load intervals exactly, so an off-by-one in the timer shows as a wrong count. It also runs a sequence that pulls INIT low after the second byte and one in which DONE never arrives. In those runs it checks that clocking stops, that the matching flag is set, and that the timeout fires after exactly DONE_WAIT extra clocks. A start pulse in the middle of a load must not pulse the program line again, and a start after an error must clear the flags.

// File: rtl/ss_cfg_pkg.sv
package ss_cfg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PROG,
        ST_WAIT_INIT,
        ST_SHIFT,
        ST_WAIT_DONE,
        ST_POST_RESET,
        ST_POST_WAIT,
        ST_READY,
        ST_ERROR
    } seq_state_e;

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/ss_delay_timer.sv
module ss_delay_timer #(
    parameter int unsigned TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] val_i,
    output logic          zero_o
);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/ss_bit_shifter.sv
module ss_bit_shifter #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              flush_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              valid_i,
    input  logic              last_i,
    output logic              ready_o,
    output logic              cclk_o,
    output logic              din_o,
    output logic              last_done_o
);

    localparam int unsigned CW = $clog2(DATA_W + 1);

    typedef struct packed {
        logic [DATA_W-1:0] sr;
        logic [CW-1:0]     left;
        logic              phase;
        logic              last;
    } shf_t;

    shf_t sh_d, sh_q;
    logic final_bit;
    logic take;

    always_comb begin
        sh_d      = sh_q;
        final_bit = (sh_q.left == CW'(1)) && sh_q.phase;
        ready_o   = en_i && ((sh_q.left == '0) || (final_bit && !sh_q.last));
        take      = ready_o && valid_i;
        last_done_o = en_i && final_bit && sh_q.last;

        if (en_i) begin
            if (sh_q.left != '0) begin
                if (!sh_q.phase) begin
                    sh_d.phase = 1'b1;
                end else begin
                    sh_d.phase = 1'b0;
                    sh_d.sr    = {sh_q.sr[DATA_W-2:0], 1'b0};
                    sh_d.left  = sh_q.left - CW'(1);
                end
            end
            if (take) begin
                sh_d.sr    = data_i;
                sh_d.left  = CW'(DATA_W);
                sh_d.phase = 1'b0;
                sh_d.last  = last_i;
            end
        end else if (flush_i) begin
            sh_d.left  = '0;
            sh_d.phase = !sh_q.phase;
        end else begin
            sh_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign cclk_o = sh_q.phase;
    assign din_o  = sh_q.sr[DATA_W-1];

endmodule

// File: rtl/ss_cfg_sequencer.sv
module ss_cfg_sequencer
    import ss_cfg_pkg::*;
#(
    parameter int unsigned TW        = 16,
    parameter int unsigned PROG_CYC  = 64,
    parameter int unsigned DELAY_CYC = 20000,
    parameter int unsigned DONE_WAIT = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          init_n_i,
    input  logic          done_i,
    input  logic          last_done_i,
    input  logic          tmr_zero_i,
    output logic          tmr_load_o,
    output logic [TW-1:0] tmr_val_o,
    output logic          shift_en_o,
    output logic          flush_o,
    output logic          prog_n_o,
    output logic          user_rst_n_o,
    output logic          io_en_n_o,
    output logic          busy_o,
    output logic          ready_o,
    output logic          err_init_o,
    output logic          err_timeout_o
);

    localparam logic [TW-1:0] PROG_LOAD  = TW'(PROG_CYC - 1);
    localparam logic [TW-1:0] DELAY_LOAD = TW'(DELAY_CYC - 1);
    localparam logic [TW-1:0] DONE_LOAD  = TW'(2 * DONE_WAIT - 1);

    typedef struct packed {
        seq_state_e st;
        logic [1:0] init_s;
        logic [1:0] done_s;
        logic       e_init;
        logic       e_to;
    } seq_t;

    seq_t sq_d, sq_q;
    logic init_high;
    logic done_high;

    always_comb begin
        sq_d        = sq_q;
        sq_d.init_s = {sq_q.init_s[0], init_n_i};
        sq_d.done_s = {sq_q.done_s[0], done_i};
        init_high   = sq_q.init_s[1];
        done_high   = sq_q.done_s[1];
        tmr_load_o  = 1'b0;
        tmr_val_o   = '0;

        case (sq_q.st)
            ST_IDLE, ST_READY, ST_ERROR: begin
                if (start_i) begin
                    sq_d.st     = ST_PROG;
                    sq_d.e_init = 1'b0;
                    sq_d.e_to   = 1'b0;
                    tmr_load_o  = 1'b1;
                    tmr_val_o   = PROG_LOAD;
                end
            end
            ST_PROG: begin
                if (tmr_zero_i) begin
                    sq_d.st = ST_WAIT_INIT;
                end
            end
            ST_WAIT_INIT: begin
                if (init_high) begin
                    sq_d.st = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (!init_high) begin
                    sq_d.st     = ST_ERROR;
                    sq_d.e_init = 1'b1;
                end else if (last_done_i) begin
                    sq_d.st    = ST_WAIT_DONE;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = DONE_LOAD;
                end
            end
            ST_WAIT_DONE: begin
                if (done_high) begin
                    sq_d.st    = ST_POST_RESET;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = DELAY_LOAD;
                end else if (tmr_zero_i) begin
                    sq_d.st   = ST_ERROR;
                    sq_d.e_to = 1'b1;
                end
            end
            ST_POST_RESET: begin
                if (tmr_zero_i) begin
                    sq_d.st    = ST_POST_WAIT;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = DELAY_LOAD;
                end
            end
            ST_POST_WAIT: begin
                if (tmr_zero_i) begin
                    sq_d.st = ST_READY;
                end
            end
            default: begin
                sq_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q.st     <= ST_IDLE;
            sq_q.init_s <= 2'b11;
            sq_q.done_s <= 2'b00;
            sq_q.e_init <= 1'b0;
            sq_q.e_to   <= 1'b0;
        end else begin
            sq_q <= sq_d;
        end
    end

    always_comb begin
        shift_en_o   = (sq_q.st == ST_SHIFT);
        flush_o      = (sq_q.st == ST_WAIT_DONE);
        prog_n_o     = (sq_q.st != ST_PROG);
        user_rst_n_o = !(sq_q.st inside {ST_PROG, ST_WAIT_INIT, ST_SHIFT,
                                          ST_WAIT_DONE, ST_POST_RESET, ST_ERROR});
        io_en_n_o    = !(sq_q.st inside {ST_POST_RESET, ST_POST_WAIT, ST_READY});
        busy_o       = (sq_q.st inside {ST_PROG, ST_WAIT_INIT, ST_SHIFT,
                                        ST_WAIT_DONE, ST_POST_RESET, ST_POST_WAIT});
        ready_o      = (sq_q.st == ST_READY);
        err_init_o   = sq_q.e_init;
        err_timeout_o = sq_q.e_to;
    end

endmodule

// File: rtl/fpga_ss_loader.sv
module fpga_ss_loader
    import ss_cfg_pkg::*;
#(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned CLK_HZ    = 200_000_000,
    parameter int unsigned DELAY_US  = 100,
    parameter int unsigned PROG_CYC  = 64,
    parameter int unsigned DONE_WAIT = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] s_data_i,
    input  logic              s_valid_i,
    input  logic              s_last_i,
    output logic              s_ready_o,
    output logic              prog_n_o,
    input  logic              init_n_i,
    input  logic              done_i,
    output logic              cclk_o,
    output logic              din_o,
    output logic              user_rst_n_o,
    output logic              io_en_n_o,
    output logic              busy_o,
    output logic              ready_o,
    output logic              err_init_o,
    output logic              err_timeout_o
);

    localparam int unsigned DELAY_CYC = (CLK_HZ / 1_000_000) * DELAY_US;
    localparam int unsigned TMAX      = max3(DELAY_CYC, PROG_CYC, 2 * DONE_WAIT);
    localparam int unsigned TW        = $clog2(TMAX + 1);

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;
    logic          shift_en;
    logic          flush;
    logic          last_done;

    ss_cfg_sequencer #(
        .TW        (TW),
        .PROG_CYC  (PROG_CYC),
        .DELAY_CYC (DELAY_CYC),
        .DONE_WAIT (DONE_WAIT)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .init_n_i      (init_n_i),
        .done_i        (done_i),
        .last_done_i   (last_done),
        .tmr_zero_i    (tmr_zero),
        .tmr_load_o    (tmr_load),
        .tmr_val_o     (tmr_val),
        .shift_en_o    (shift_en),
        .flush_o       (flush),
        .prog_n_o      (prog_n_o),
        .user_rst_n_o  (user_rst_n_o),
        .io_en_n_o     (io_en_n_o),
        .busy_o        (busy_o),
        .ready_o       (ready_o),
        .err_init_o    (err_init_o),
        .err_timeout_o (err_timeout_o)
    );

    ss_delay_timer #(
        .TW (TW)
    ) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    ss_bit_shifter #(
        .DATA_W (DATA_W)
    ) u_shf (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (shift_en),
        .flush_i     (flush),
        .data_i      (s_data_i),
        .valid_i     (s_valid_i),
        .last_i      (s_last_i),
        .ready_o     (s_ready_o),
        .cclk_o      (cclk_o),
        .din_o       (din_o),
        .last_done_o (last_done)
    );

endmodule

// File: rtl/ss_loader_chk.sv
module ss_loader_chk (
    input logic clk,
    input logic rst_n,
    input logic s_ready_o,
    input logic prog_n_o,
    input logic cclk_o,
    input logic din_o,
    input logic user_rst_n_o,
    input logic io_en_n_o,
    input logic busy_o,
    input logic ready_o,
    input logic err_init_o
);

    // R2 / R3: the stream opens only while the target is held and its I/Os are off
    p_stream_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready_o |-> (busy_o && !user_rst_n_o && io_en_n_o && prog_n_o));

    // R2: no clocking or data acceptance during the program pulse
    p_prog_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n_o |-> (!cclk_o && !s_ready_o));

    // R4: the configuration clock is never high two cycles running
    p_half_rate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cclk_o |=> !cclk_o);

    // R4: data is set up before the rising edge
    p_din_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cclk_o) |-> $stable(din_o));

    // R6: an INIT fault leaves the block idle and silent
    p_init_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_init_o |-> (!busy_o && !cclk_o && !s_ready_o));

    // R7: ready means I/Os enabled and reset released
    p_ready_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (!io_en_n_o && user_rst_n_o));

    // R9: once past the program pulse, the pulse does not return within a load
    p_no_reprog_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && prog_n_o) |=> prog_n_o);

endmodule

bind fpga_ss_loader ss_loader_chk u_chk (.*);

// File: tb/tb_fpga_ss_loader.sv
`timescale 1ns/1ps
module tb_fpga_ss_loader;

    localparam int unsigned CLK_HZ    = 200_000_000;
    localparam int unsigned DELAY_US  = 1;
    localparam int unsigned PROG_CYC  = 8;
    localparam int unsigned DONE_WAIT = 16;
    localparam int unsigned DLY       = (CLK_HZ / 1_000_000) * DELAY_US;
    localparam int          NVEC      = 6;

    // entry = {first byte, byte count, fault (0 none, 1 INIT drop, 2 no DONE), start poke}
    localparam logic [14:0] VECS [0:NVEC-1] = '{
        {8'hA5, 4'd3, 2'd0, 1'b0},
        {8'h00, 4'd1, 2'd0, 1'b0},
        {8'hFF, 4'd4, 2'd0, 1'b1},
        {8'h3C, 4'd5, 2'd1, 1'b0},
        {8'h81, 4'd2, 2'd2, 1'b0},
        {8'h7E, 4'd2, 2'd0, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] s_data_i = 8'h00;
    logic       s_valid_i = 1'b0;
    logic       s_last_i = 1'b0;
    logic       s_ready_o, prog_n_o, cclk_o, din_o;
    logic       user_rst_n_o, io_en_n_o, busy_o, ready_o, err_init_o, err_timeout_o;
    logic       init_n_i;
    logic       done_i;

    always #2.5 clk = ~clk;

    fpga_ss_loader #(
        .DATA_W    (8),
        .CLK_HZ    (CLK_HZ),
        .DELAY_US  (DELAY_US),
        .PROG_CYC  (PROG_CYC),
        .DONE_WAIT (DONE_WAIT)
    ) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .s_data_i      (s_data_i),
        .s_valid_i     (s_valid_i),
        .s_last_i      (s_last_i),
        .s_ready_o     (s_ready_o),
        .prog_n_o      (prog_n_o),
        .init_n_i      (init_n_i),
        .done_i        (done_i),
        .cclk_o        (cclk_o),
        .din_o         (din_o),
        .user_rst_n_o  (user_rst_n_o),
        .io_en_n_o     (io_en_n_o),
        .busy_o        (busy_o),
        .ready_o       (ready_o),
        .err_init_o    (err_init_o),
        .err_timeout_o (err_timeout_o)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input logic [7:0] first, input int idx);
        return first + 8'(idx * 8'h3B);
    endfunction

    // ---------------- target model ----------------
    logic       init_drv = 1'b1;
    logic       force_init = 1'b0;
    logic       done_drv = 1'b0;
    int         rel_cnt = 0;
    int         rx_bits = 0;
    int         extra = 0;
    logic [7:0] rx_sr = 8'h00;
    int         cur_n = 1;
    logic [7:0] cur_first = 8'h00;
    int         cur_fault = 0;
    int         prog_falls = 0;
    int         ready_bad = 0;
    int         din_bad = 0;
    int         gap_bad = 0;
    int         byte_bad = 0;
    int         gap = 0;
    bit         have_rise = 1'b0;
    logic       prev_cclk = 1'b0;
    logic       prev_din = 1'b0;
    logic       prev_prog = 1'b1;

    assign init_n_i = init_drv && !force_init;
    assign done_i   = done_drv;

    always @(negedge clk) begin
        logic [7:0] nb;
        prev_cclk <= cclk_o;
        prev_din  <= din_o;
        prev_prog <= prog_n_o;
        if (prev_prog && !prog_n_o) prog_falls <= prog_falls + 1;
        if (!prog_n_o) begin
            init_drv <= 1'b0;
            rel_cnt  <= 5;
            done_drv <= 1'b0;
        end else if (rel_cnt > 0) begin
            rel_cnt <= rel_cnt - 1;
            if (rel_cnt == 1) init_drv <= 1'b1;
        end
        if (s_ready_o && !init_n_i && !force_init) ready_bad <= ready_bad + 1;
        gap <= gap + 1;
        if (cclk_o && !prev_cclk) begin
            gap <= 0;
            if (din_o !== prev_din) din_bad <= din_bad + 1;
            if (have_rise && busy_o && (gap + 1) != 2) gap_bad <= gap_bad + 1;
            have_rise <= 1'b1;
            if (rx_bits < cur_n * 8) begin
                nb = {rx_sr[6:0], din_o};
                rx_sr   <= nb;
                rx_bits <= rx_bits + 1;
                if (((rx_bits + 1) % 8) == 0 && nb != exp_byte(cur_first, rx_bits / 8))
                    byte_bad <= byte_bad + 1;
                if (cur_fault == 1 && rx_bits + 1 == 16) force_init <= 1'b1;
            end else begin
                extra <= extra + 1;
                if (cur_fault == 0 && extra + 1 == 4) done_drv <= 1'b1;
            end
        end
    end

    // ---------------- one configuration run ----------------
    task automatic run_cfg(input logic [7:0] first, input int n, input int fault,
                           input bit poke);
        int cnt;
        int c1;
        int c2;
        int w;
        int hi;
        bit ok;
        @(negedge clk);
        cur_first = first; cur_n = n; cur_fault = fault;
        rx_bits = 0; extra = 0; have_rise = 1'b0; force_init = 1'b0;
        prog_falls = 0; ready_bad = 0; din_bad = 0; gap_bad = 0; byte_bad = 0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(!err_init_o && !err_timeout_o, "R10", "flags cleared by start",
            int'(err_init_o) + int'(err_timeout_o), 0);
        cnt = 0;
        while (!prog_n_o && cnt < 1000) begin
            cnt++;
            @(negedge clk);
        end
        chk(cnt == PROG_CYC, "R2", "program pulse width", cnt, PROG_CYC);
        chk(!user_rst_n_o && io_en_n_o, "R2", "reset held, I/O off after program",
            {user_rst_n_o, io_en_n_o}, 1);

        for (int i = 0; i < n; i++) begin
            s_data_i  = exp_byte(first, i);
            s_last_i  = (i == n - 1);
            s_valid_i = 1'b1;
            if (poke && i == 1) start_i = 1'b1;
            w = 0;
            do begin
                ok = s_ready_o;
                @(negedge clk);
                start_i = 1'b0;
                w++;
            end while (!ok && !err_init_o && w < 2000);
            if (err_init_o) break;
        end
        s_valid_i = 1'b0;
        s_last_i  = 1'b0;

        c1 = 0; c2 = 0; w = 0;
        while (!(ready_o || err_init_o || err_timeout_o) && w < 5000) begin
            if (!io_en_n_o && !user_rst_n_o) c1++;
            if (!io_en_n_o && user_rst_n_o) c2++;
            w++;
            @(negedge clk);
        end

        chk(ready_bad == 0, "R3", "s_ready high while INIT low", ready_bad, 0);
        chk(din_bad == 0, "R4", "din changed at rising edge", din_bad, 0);
        chk(byte_bad == 0, "R4", "received byte mismatch", byte_bad, 0);
        chk(gap_bad == 0, "R5", "clock gap not 2 cycles", gap_bad, 0);
        chk(prog_falls == 1, "R9", "program pulses per run", prog_falls, 1);

        if (fault == 0) begin
            chk(ready_o, "R7", "ready after DONE", ready_o, 1);
            chk(rx_bits == n * 8, "R4", "bits received", rx_bits, n * 8);
            chk(c1 == DLY, "R7", "reset hold with I/O enabled", c1, DLY);
            chk(c2 == DLY, "R7", "wait after reset release", c2, DLY);
            chk(!busy_o && !err_init_o && !err_timeout_o, "R10", "clean finish",
                {busy_o, err_init_o, err_timeout_o}, 0);
        end else if (fault == 1) begin
            chk(err_init_o && !err_timeout_o, "R6", "INIT error flag",
                {err_init_o, err_timeout_o}, 2);
            chk(rx_bits < n * 8, "R6", "bits sent after abort", rx_bits, n * 8 - 1);
            hi = 0;
            for (int k = 0; k < 8; k++) begin
                if (cclk_o || s_ready_o || busy_o) hi++;
                @(negedge clk);
            end
            chk(hi == 0, "R6", "activity after INIT abort", hi, 0);
        end else begin
            chk(err_timeout_o && !err_init_o, "R8", "timeout flag",
                {err_timeout_o, err_init_o}, 2);
            chk(extra == DONE_WAIT, "R8", "extra clocks before timeout", extra, DONE_WAIT);
            chk(io_en_n_o && !ready_o, "R8", "I/O stays disabled",
                {io_en_n_o, ready_o}, 2);
        end
        repeat (4) @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // ---------------- main ----------------
    initial begin
        repeat (3) @(negedge clk);
        chk(prog_n_o && user_rst_n_o && io_en_n_o && !cclk_o && !s_ready_o, "R1",
            "pins in reset", {prog_n_o, user_rst_n_o, io_en_n_o, cclk_o, s_ready_o}, 5'b11100);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy_o && !ready_o && !err_init_o && !err_timeout_o, "R1", "status after reset",
            {busy_o, ready_o, err_init_o, err_timeout_o}, 0);
        chk(prog_n_o && user_rst_n_o && io_en_n_o && !cclk_o, "R1", "idle pins",
            {prog_n_o, user_rst_n_o, io_en_n_o, cclk_o}, 4'b1110);

        for (int v = 0; v < NVEC; v++) begin
            run_cfg(VECS[v][14:7], int'(VECS[v][6:3]), int'(VECS[v][2:1]), VECS[v][0]);
        end

        // reset in the middle of a load returns every pin to idle (R1)
        @(negedge clk);
        cur_n = 4; cur_first = 8'h11; cur_fault = 0; rx_bits = 0; extra = 0;
        force_init = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        s_data_i = 8'h11; s_valid_i = 1'b1;
        repeat (PROG_CYC + 20) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        s_valid_i = 1'b0;
        chk(prog_n_o && user_rst_n_o && io_en_n_o && !cclk_o && !s_ready_o && !busy_o,
            "R1", "reset mid-load", {prog_n_o, user_rst_n_o, io_en_n_o, cclk_o, s_ready_o, busy_o},
            6'b111000);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule